// File: doc/BRIEF.md
# Tagged Burst Sequencer for a Multi-Input Data Card

This block sits on a data card that collects event data from several independent inputs and ships it over a shared bus to processing nodes. When an event is announced, it walks its inputs in ascending order. For each input that holds data it requests the bus and waits for grant. It then sends that input's words as one unbroken burst and releases the bus before it moves to the next input. Releasing the bus between inputs gives the higher-priority processing nodes a chance to take it, so no single event holds the bus for long.

Every word leaves with an 8-bit tag. The upper nibble is an event number that the card counts up on its own. The lower nibble is a source code. One source code is kept back for node-to-node messaging and never labels card data. An input that has nothing for the current event costs no bus request.

Top module: `burst_tag_seq`

## Requirements
- R1: `out_tag[7:4]` carries the event number and `out_tag[3:0]` the source code of the word on `out_data`.
- R2: Input i (0..3) is labelled with source code i. The reserved code 4'hF (parameter `RSV_SID`) never appears in `out_tag[3:0]`.
- R3: The event number is 0 after reset. It is the same for all bursts of one event. It steps by one, modulo 16, once all inputs of that event are finished, including an event in which every input is empty.
- R4: Inputs are served in ascending index order. Input i with length L sends exactly L words, in the order it supplies them through `src_pop[i]`, with `out_last` high only on the L-th word.
- R5: No word is offered (`out_valid`) unless `bus_gnt` is high. While grant is withheld, the burst does not start.
- R6: `bus_req` stays high from its rise until the last word of the burst is accepted. It is low in the cycle after that acceptance, so each non-empty input causes exactly one rising edge of `bus_req`.
- R7: An input whose length is 0 is skipped, and no bus request is raised for it.
- R8: `evt_ready` is high only while no event is in progress. An `evt_start` pulse while `evt_ready` is low is ignored.
- R9: After reset, `bus_req` and `out_valid` are low and `evt_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, `out_tag` and `out_data` hold their values and no `src_pop` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start | input | 1 | Pulse announcing a new event, taken when `evt_ready` is high |
| evt_ready | output | 1 | Sequencer idle and able to take an event |
| src_len | input | N_SRC*LEN_W | Word count per input for the announced event, input i in slice i |
| src_data | input | N_SRC*DATA_W | Head word offered by each input, input i in slice i |
| src_pop | output | N_SRC | One-cycle strobe: head word of input i was sent |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| out_valid | output | 1 | Word on `out_data` is valid |
| out_ready | input | 1 | Receiver accepts the word this cycle |
| out_data | output | DATA_W | Outgoing data word |
| out_tag | output | 8 | Event number (upper nibble) and source code (lower nibble) |
| out_last | output | 1 | Final word of the current burst |

## Verification
The hardest case to reach from the ports is a burst that is stalled by the receiver while a processing node is also holding off the grant. In that case the request must stay up, the tag must stay put and no word may be popped. The bench reaches it by withholding grant for a window after a request rises and by running the receiver's ready through an irregular on/off pattern. It also pulses `evt_start` again in the middle of an event, and runs more than sixteen events so that the event number wraps.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int EVT_W = 4;
  localparam int SID_W = 4;
  localparam int TAG_W = EVT_W + SID_W;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SCAN = 3'd1,
    ST_REQ  = 3'd2,
    ST_XFER = 3'd3,
    ST_REL  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/bts_event_ctr.sv
module bts_event_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] evt_id
);
  logic [W-1:0] evt_d;

  always_comb begin
    evt_d = evt_id;
    if (adv) evt_d = evt_id + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_id <= '0;
    else if (adv) evt_id <= evt_d;
  end
endmodule

// File: rtl/bts_word_ctr.sv
module bts_word_ctr #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LEN_W'(1));
endmodule

// File: rtl/bts_src_mux.sv
module bts_src_mux #(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic [IDX_W-1:0]        sel,
  input  logic                    pop,
  input  logic [N_SRC*DATA_W-1:0] src_data,
  output logic [N_SRC-1:0]        src_pop,
  output logic [DATA_W-1:0]       data_out
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_pop
    assign src_pop[g] = pop && (sel == IDX_W'(g));
  end

  always_comb begin
    data_out = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == IDX_W'(i)) data_out = src_data[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/burst_tag_seq.sv
module burst_tag_seq
  import bts_pkg::*;
#(
  parameter int               N_SRC   = 4,
  parameter int               DATA_W  = 16,
  parameter int               LEN_W   = 6,
  parameter logic [SID_W-1:0] RSV_SID = 4'hF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_start,
  output logic                    evt_ready,
  input  logic [N_SRC*LEN_W-1:0]  src_len,
  input  logic [N_SRC*DATA_W-1:0] src_data,
  output logic [N_SRC-1:0]        src_pop,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic [TAG_W-1:0]        out_tag,
  output logic                    out_last
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SRC - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [LEN_W-1:0] len_q [N_SRC];
  logic             len_en;
  logic [LEN_W-1:0] cur_len;
  logic             evt_adv, cnt_load, word_last, fire;
  logic [EVT_W-1:0] evt_id;
  logic [SID_W-1:0] sid;

  assign len_en = (st_q == ST_IDLE) && evt_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) len_q[i] <= '0;
    end else if (len_en) begin
      for (int i = 0; i < N_SRC; i++) len_q[i] <= src_len[i*LEN_W +: LEN_W];
    end
  end

  always_comb begin
    cur_len = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (idx_q == IDX_W'(i)) cur_len = len_q[i];
    end
  end

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    evt_adv  = 1'b0;
    cnt_load = 1'b0;
    case (st_q)
      ST_IDLE: if (evt_start) begin
        st_d  = ST_SCAN;
        idx_d = '0;
      end
      ST_SCAN: begin
        if (cur_len != '0) begin
          cnt_load = 1'b1;
          st_d     = ST_REQ;
        end else if (idx_q == IDX_LAST) begin
          evt_adv = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_REQ:  if (bus_gnt) st_d = ST_XFER;
      ST_XFER: if (fire && word_last) st_d = ST_REL;
      ST_REL: begin
        if (idx_q == IDX_LAST) begin
          evt_adv = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_SCAN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign idx_en = (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign evt_ready = (st_q == ST_IDLE);
  assign bus_req   = (st_q == ST_REQ) || (st_q == ST_XFER);
  assign out_valid = (st_q == ST_XFER) && bus_gnt;
  assign fire      = out_valid && out_ready;
  assign out_last  = out_valid && word_last;

  always_comb begin
    sid = SID_W'(idx_q);
    if (sid >= RSV_SID) sid = sid + 1'b1;
  end

  assign out_tag = {evt_id, sid};

  bts_event_ctr #(.W(EVT_W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (evt_adv),
    .evt_id (evt_id)
  );

  bts_word_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cur_len),
    .dec      (fire),
    .last     (word_last)
  );

  bts_src_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .sel      (idx_q),
    .pop      (fire),
    .src_data (src_data),
    .src_pop  (src_pop),
    .data_out (out_data)
  );
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int          DATA_W  = 16,
  parameter logic [3:0]  RSV_SID = 4'hF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [7:0]        out_tag,
  input logic [DATA_W-1:0] out_data
);
  // R2: reserved source code never labels card data
  p_no_rsv_sid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag[3:0] != RSV_SID));

  // R5: a word is only offered under grant
  p_valid_needs_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> bus_gnt);

  // R6: request held until the last word is accepted
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(out_valid && out_ready && out_last)) |=> bus_req);

  // R6: request released right after the final word
  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !bus_req);

  // R8: idle sequencer does not request the bus
  p_idle_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |-> !bus_req);

  // R10: stalled word keeps its tag and data
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && bus_gnt) |=> ($stable(out_tag) && $stable(out_data)));
endmodule

bind burst_tag_seq bts_checker #(.DATA_W(DATA_W), .RSV_SID(RSV_SID)) u_bts_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_ready (evt_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_tag   (out_tag),
  .out_data  (out_data)
);

// File: tb/test_burst_tag_seq.sv
module test_burst_tag_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 4;
  localparam int DW     = 16;
  localparam int LW     = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic evt_start;
  logic evt_ready;
  logic [N*LW-1:0] src_len;
  logic [N*DW-1:0] src_data;
  logic [N-1:0]    src_pop;
  logic bus_req, bus_gnt, out_valid, out_ready, out_last;
  logic [DW-1:0] out_data;
  logic [7:0]    out_tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side models
  int  ptr [N];
  int  exp_ptr [N];
  int  exp_evt = 0;
  bit  node_hold = 0;
  bit  rdy_irregular = 0;
  int  rdy_cnt = 0;
  logic [7:0]  cap_tag  [256];
  logic [DW-1:0] cap_data [256];
  logic        cap_last [256];
  int  cap_n = 0;
  int  req_rises = 0;
  int  viol_gnt = 0;
  int  viol_stall = 0;
  int  pops_in_stall = 0;
  logic prev_req = 0;
  logic prev_stall = 0;
  logic [7:0]  prev_tag;
  logic [DW-1:0] prev_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_tag_seq #(.N_SRC(N), .DATA_W(DW), .LEN_W(LW)) i_burst_tag_seq (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_ready(evt_ready),
    .src_len(src_len), .src_data(src_data), .src_pop(src_pop),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .out_last(out_last)
  );

  // arbiter model: processing nodes win while node_hold is set
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !node_hold;
  end

  // receiver ready pattern
  always @(posedge clk) begin
    rdy_cnt   <= rdy_cnt + 1;
    out_ready <= rdy_irregular ? (((rdy_cnt * 7) % 5) > 1) : 1'b1;
  end

  // input models: word k of input i reads {i, k}
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) if (rst_n && src_pop[i]) ptr[i] <= ptr[i] + 1;
  end
  always_comb begin
    for (int i = 0; i < N; i++) src_data[i*DW +: DW] = {4'(i), 12'(ptr[i])};
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !bus_gnt) viol_gnt++;
      if (prev_stall && out_valid && (out_tag != prev_tag || out_data != prev_data)) viol_stall++;
      if (out_valid && !out_ready && src_pop != '0) pops_in_stall++;
      if (bus_req && !prev_req) req_rises++;
      if (out_valid && out_ready && cap_n < 256) begin
        cap_tag[cap_n]  = out_tag;
        cap_data[cap_n] = out_data;
        cap_last[cap_n] = out_last;
        cap_n++;
      end
      prev_req   = bus_req;
      prev_stall = out_valid && !out_ready;
      prev_tag   = out_tag;
      prev_data  = out_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (!evt_ready && n < 5000);
  endtask

  // starts an event, optionally pulses a second start mid-event, checks all words
  task automatic run_event(input int l0, input int l1, input int l2, input int l3,
                           input bit extra_start, input int hold_cycles);
    int lens [N];
    int k = 0;
    int nz = 0;
    int tot = 0;
    lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
    @(negedge clk);
    cap_n = 0; req_rises = 0;
    node_hold = (hold_cycles > 0);
    for (int i = 0; i < N; i++) src_len[i*LW +: LW] = LW'(lens[i]);
    evt_start = 1'b1;
    @(negedge clk);
    evt_start = 1'b0;
    chk(!evt_ready, "R8 busy after start", evt_ready, 0);
    if (hold_cycles > 0) begin
      repeat (hold_cycles) @(negedge clk);
      chk(cap_n == 0 && !out_valid, "R5 no word while grant withheld", cap_n, 0);
      node_hold = 0;
    end
    if (extra_start) begin
      repeat (2) @(negedge clk);
      for (int i = 0; i < N; i++) src_len[i*LW +: LW] = LW'(9);
      evt_start = 1'b1;
      @(negedge clk);
      evt_start = 1'b0;
    end
    wait_idle();
    for (int i = 0; i < N; i++) begin
      tot += lens[i];
      if (lens[i] != 0) nz++;
    end
    chk(cap_n == tot, "R4 word count of event", cap_n, tot);
    chk(req_rises == nz, "R6 R7 one request per non-empty input", req_rises, nz);
    for (int i = 0; i < N; i++) begin
      for (int w = 0; w < lens[i]; w++) begin
        if (k < cap_n) begin
          chk(cap_tag[k] == {4'(exp_evt), 4'(i)}, "R1 R2 R3 tag", cap_tag[k], {4'(exp_evt), 4'(i)});
          chk(cap_data[k] == {4'(i), 12'(exp_ptr[i] + w)}, "R4 data order", cap_data[k],
              {4'(i), 12'(exp_ptr[i] + w)});
          chk(cap_last[k] == (w == lens[i] - 1), "R4 last marker", cap_last[k], (w == lens[i] - 1));
        end
        k++;
      end
      exp_ptr[i] += lens[i];
    end
    exp_evt = (exp_evt + 1) % 16;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!bus_req, "R9 request low", bus_req, 0);
    chk(!out_valid, "R9 valid low", out_valid, 0);
    chk(evt_ready, "R9 ready high", evt_ready, 1);
  endtask

  task automatic t_basic();
    run_event(3, 1, 4, 2, 0, 0);
    run_event(1, 5, 2, 7, 0, 0);
  endtask

  task automatic t_skip();
    run_event(0, 3, 0, 2, 0, 0);   // R7 skip of inputs 0 and 2
    run_event(0, 0, 0, 0, 0, 0);   // R3 empty event still counts
    run_event(2, 0, 0, 1, 0, 0);
  endtask

  task automatic t_priority_stall();
    rdy_irregular = 1;
    run_event(6, 2, 5, 3, 0, 12);  // R5 grant withheld, R10 stalls
    rdy_irregular = 0;
    chk(viol_stall == 0, "R10 stalled word held", viol_stall, 0);
    chk(pops_in_stall == 0, "R10 no pop while stalled", pops_in_stall, 0);
  endtask

  task automatic t_busy_start();
    run_event(4, 4, 1, 3, 1, 0);   // R8 mid-event start ignored
    run_event(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_wrap();
    for (int e = 0; e < 17; e++) run_event(1, 0, 2, 1, 0, 0);  // R3 wrap modulo 16
    chk(viol_gnt == 0, "R5 valid only under grant", viol_gnt, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin ptr[i] = 0; exp_ptr[i] = 0; end
    rst_n = 1'b0; evt_start = 1'b0; src_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_skip();
    t_priority_stall();
    t_busy_start();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule